// File: doc/BRIEF.md
# Ping-Pong Block Read Buffer

This block sits between a RAM block-read path and a bus reply path. It holds two block-sized halves. A RAM read can fill one half while the other half still holds an earlier block that waits for its reply slot. The fill side delivers a block as a burst of words. The first word carries a start flag and the index of the requested word. The following words continue in cyclic order, wrapping modulo the block size. The drain side asks for the next block with a one-cycle start pulse. It then receives the words in the same order they arrived, each tagged with its word index, and the final word is flagged.

Internal selectors allocate halves in strict alternation, and blocks are drained in the order they were filled. A drain may be started as soon as a half has been allocated. This lets the reply begin while the fill is still in progress. The drain side never presents a word before the cycle after the one in which it was written. When it catches up with the fill, it stalls. A half returns to the free pool only once every word in it has been drained. When no half is free, the fill side sees a full flag, and a block offered at that time is discarded.

Top module: `pp_read_buffer`

## Requirements
- R1: After reset both halves are empty (half_empty = 2'b11, half_full = 2'b00), wr_full and rd_valid are low, and the first accepted block goes to half 0 (bit 0 of the status vectors).
- R2: A block is BLK_WORDS words. The first has wr_valid and wr_start high and wr_first giving its word index. Each later word has wr_valid high and wr_start low, and its index is the previous one plus one, modulo BLK_WORDS. Drained words appear in arrival order, with rd_idx giving each word's index.
- R3: Accepted blocks occupy halves 0,1,0,1,… and are drained in the same order they were accepted.
- R4: A new block may be written into the free half while the other half waits to be drained or is being drained.
- R5: When both halves are occupied, wr_full is high and a block started then is discarded entirely, including its following words.
- R6: rd_start is accepted only when no drain is running and the next half to drain is occupied, even if that half is still filling; otherwise it is ignored. With a drain armed the cycle after a gapless fill begins (fill start in cycle c), rd_valid first rises in cycle c+3, the same cycle the last word is written.
- R7: A word written in cycle c is presented on rd_valid no earlier than cycle c+2. When the drain reaches the fill, output stalls until the next word is written.
- R8: A half is freed only after all its words are drained; its half_empty bit is high in the same cycle the final word is presented.
- R9: rd_last is high with the final word of each block and only then, and rd_valid is low in the next cycle.
- R10: A half_full bit is high once all words of that half are written and clears when the half is freed.
- R11: A word carrying wr_start while a block is still being filled is ignored, and the open block continues normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Fill word valid |
| wr_start | input | 1 | Marks first word of a block |
| wr_first | input | IDX_W | Word index of the first word |
| wr_data | input | DATA_W | Fill word |
| wr_full | output | 1 | No half free, new block would be refused |
| rd_start | input | 1 | Request to drain the next occupied half |
| rd_valid | output | 1 | Drained word valid |
| rd_data | output | DATA_W | Drained word |
| rd_idx | output | IDX_W | Word index of the drained word |
| rd_last | output | 1 | Final word of the block |
| half_empty | output | 2 | Per-half free flag |
| half_full | output | 2 | Per-half all-words-written flag |

## Verification
A sweep covers every starting word index, inter-word fill gaps of zero to two cycles, and drain requests issued one to four cycles after the fill starts. This separates drains that trail the fill from drains that overtake it and must stall. Directed sequences fill both halves and then offer a third block, to show that the refused block never reaches the output. They also overlap a fill with a drain, inject a stray start inside an open block, and issue drain requests with nothing occupied. Exact cycle checks on a gapless fill and on a gapped fill show the early drain start and the one-cycle write-to-read spacing.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_OPEN = 1'b1
    } fill_st_t;

    typedef enum logic {
        DRN_IDLE = 1'b0,
        DRN_RUN  = 1'b1
    } drn_st_t;

    // cyclic word index: (base + offset) mod n
    function automatic int unsigned wrap_add(int unsigned base, int unsigned offset,
                                             int unsigned n);
        return (base + offset) % n;
    endfunction

endpackage

// File: rtl/pp_half_store.sv
module pp_half_store #(
    parameter int DATA_W    = 64,
    parameter int BLK_WORDS = 4,
    localparam int IDX_W    = $clog2(BLK_WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              we_half,
    input  logic [IDX_W-1:0]  we_slot,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic              re_half,
    input  logic [IDX_W-1:0]  re_slot,
    output logic [DATA_W-1:0] rdata
);

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [DATA_W-1:0] bank [BLK_WORDS];

        always_ff @(posedge clk) begin
            if (we && (we_half == 1'(h))) begin
                bank[we_slot] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= re_half ? g_half[1].bank[re_slot] : g_half[0].bank[re_slot];
        end
    end

endmodule

// File: rtl/pp_fill_ctrl.sv
module pp_fill_ctrl
    import pp_buf_pkg::*;
#(
    parameter int BLK_WORDS = 4,
    localparam int IDX_W    = $clog2(BLK_WORDS),
    localparam int CNT_W    = IDX_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_valid,
    input  logic                       wr_start,
    input  logic [IDX_W-1:0]           wr_first,
    input  logic                       free_vld,
    input  logic                       free_half,
    output logic [1:0]                 occ,
    output logic [1:0][CNT_W-1:0]      wcnt,
    output logic [1:0][IDX_W-1:0]      first_idx,
    output logic                       we,
    output logic                       we_half,
    output logic [IDX_W-1:0]           we_slot,
    output logic                       wr_full
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BLK_WORDS);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BLK_WORDS - 1);

    fill_st_t fill_st;
    logic     wsel;
    logic     fhalf;
    logic     accept;
    logic     cont;

    assign wr_full = occ[wsel];
    assign accept  = wr_valid && wr_start && (fill_st == FILL_IDLE) && !occ[wsel];
    assign cont    = wr_valid && !wr_start && (fill_st == FILL_OPEN);

    assign we      = accept || cont;
    assign we_half = accept ? wsel : fhalf;
    assign we_slot = accept ? '0 : wcnt[fhalf][IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_st   <= FILL_IDLE;
            wsel      <= 1'b0;
            fhalf     <= 1'b0;
            occ       <= '0;
            wcnt      <= '0;
            first_idx <= '0;
        end else begin
            if (free_vld) begin
                occ[free_half]  <= 1'b0;
                wcnt[free_half] <= '0;
            end
            if (accept) begin
                occ[wsel]       <= 1'b1;
                wcnt[wsel]      <= CNT_W'(1);
                first_idx[wsel] <= wr_first;
                fhalf           <= wsel;
                wsel            <= ~wsel;
                fill_st         <= FILL_OPEN;
            end else if (cont) begin
                wcnt[fhalf] <= wcnt[fhalf] + CNT_W'(1);
                if (wcnt[fhalf] == LAST_CNT) begin
                    fill_st <= FILL_IDLE;
                end
            end
        end
    end

    AST_WCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (wcnt[0] <= FULL_CNT) && (wcnt[1] <= FULL_CNT)); // R10

    AST_COUNT_NEEDS_OCC: assert property (@(posedge clk) disable iff (rst)
        (wcnt[0] != '0) |-> occ[0]); // R8

endmodule

// File: rtl/pp_drain_ctrl.sv
module pp_drain_ctrl
    import pp_buf_pkg::*;
#(
    parameter int BLK_WORDS = 4,
    localparam int IDX_W    = $clog2(BLK_WORDS),
    localparam int CNT_W    = IDX_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_start,
    input  logic [1:0]                 occ,
    input  logic [1:0][CNT_W-1:0]      wcnt,
    input  logic [1:0][IDX_W-1:0]      first_idx,
    output logic                       re,
    output logic                       re_half,
    output logic [IDX_W-1:0]           re_slot,
    output logic                       free_vld,
    output logic                       free_half,
    output logic                       rd_valid,
    output logic [IDX_W-1:0]           rd_idx,
    output logic                       rd_last
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BLK_WORDS);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BLK_WORDS - 1);

    drn_st_t          drn_st;
    logic             rsel;
    logic [CNT_W-1:0] rcnt;
    logic             start_ok;
    logic             take;
    logic             last_take;

    assign start_ok  = rd_start && (drn_st == DRN_IDLE) && occ[rsel];
    assign take      = (drn_st == DRN_RUN) && (wcnt[rsel] > rcnt);
    assign last_take = take && (rcnt == LAST_CNT);

    assign re        = take;
    assign re_half   = rsel;
    assign re_slot   = rcnt[IDX_W-1:0];
    assign free_vld  = last_take;
    assign free_half = rsel;

    always_ff @(posedge clk) begin
        if (rst) begin
            drn_st   <= DRN_IDLE;
            rsel     <= 1'b0;
            rcnt     <= '0;
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_idx   <= '0;
        end else begin
            rd_valid <= take;
            rd_last  <= last_take;
            if (take) begin
                rd_idx <= IDX_W'(wrap_add(int'(first_idx[rsel]), int'(rcnt), BLK_WORDS));
            end
            if (start_ok) begin
                drn_st <= DRN_RUN;
                rcnt   <= '0;
            end else if (last_take) begin
                drn_st <= DRN_IDLE;
                rsel   <= ~rsel;
                rcnt   <= '0;
            end else if (take) begin
                rcnt <= rcnt + CNT_W'(1);
            end
        end
    end

    AST_TAKE_OCCUPIED: assert property (@(posedge clk) disable iff (rst)
        take |-> occ[rsel]); // R7

    AST_FREE_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
        free_vld |-> (wcnt[free_half] == FULL_CNT)); // R8

    AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_last) |=> !rd_valid); // R9

endmodule

// File: rtl/pp_read_buffer.sv
module pp_read_buffer #(
    parameter int DATA_W    = 64,
    parameter int BLK_WORDS = 4,
    localparam int IDX_W    = $clog2(BLK_WORDS),
    localparam int CNT_W    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic              wr_start,
    input  logic [IDX_W-1:0]  wr_first,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_start,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              rd_last,
    output logic [1:0]        half_empty,
    output logic [1:0]        half_full
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BLK_WORDS);

    logic [1:0]            occ;
    logic [1:0][CNT_W-1:0] wcnt;
    logic [1:0][IDX_W-1:0] first_idx;
    logic                  we;
    logic                  we_half;
    logic [IDX_W-1:0]      we_slot;
    logic                  re;
    logic                  re_half;
    logic [IDX_W-1:0]      re_slot;
    logic                  free_vld;
    logic                  free_half;

    pp_fill_ctrl #(.BLK_WORDS(BLK_WORDS)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_start  (wr_start),
        .wr_first  (wr_first),
        .free_vld  (free_vld),
        .free_half (free_half),
        .occ       (occ),
        .wcnt      (wcnt),
        .first_idx (first_idx),
        .we        (we),
        .we_half   (we_half),
        .we_slot   (we_slot),
        .wr_full   (wr_full)
    );

    pp_drain_ctrl #(.BLK_WORDS(BLK_WORDS)) u_drain (
        .clk       (clk),
        .rst       (rst),
        .rd_start  (rd_start),
        .occ       (occ),
        .wcnt      (wcnt),
        .first_idx (first_idx),
        .re        (re),
        .re_half   (re_half),
        .re_slot   (re_slot),
        .free_vld  (free_vld),
        .free_half (free_half),
        .rd_valid  (rd_valid),
        .rd_idx    (rd_idx),
        .rd_last   (rd_last)
    );

    pp_half_store #(.DATA_W(DATA_W), .BLK_WORDS(BLK_WORDS)) u_store (
        .clk     (clk),
        .we      (we),
        .we_half (we_half),
        .we_slot (we_slot),
        .wdata   (wr_data),
        .re      (re),
        .re_half (re_half),
        .re_slot (re_slot),
        .rdata   (rd_data)
    );

    assign half_empty = ~occ;

    for (genvar h = 0; h < 2; h++) begin : g_stat
        assign half_full[h] = (wcnt[h] == FULL_CNT);
    end

    AST_FULL_BOTH: assert property (@(posedge clk) disable iff (rst)
        wr_full |-> (half_empty == 2'b00)); // R5

    AST_FULL_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (half_full & half_empty) == 2'b00); // R10

endmodule

// File: tb/pp_read_buffer_tb_top.sv
module pp_read_buffer_tb_top;

    localparam int DW = 64;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic          wr_start = 1'b0;
    logic [1:0]    wr_first = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_full;
    logic          rd_start = 1'b0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [1:0]    rd_idx;
    logic          rd_last;
    logic [1:0]    half_empty;
    logic [1:0]    half_full;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [DW-1:0] exp_data[$];
    int            exp_idx[$];
    int            exp_wc[$];
    int            nread = 0;
    int            rhalf = 0;
    int            blk_first_cyc = 0;
    int            blk_last_cyc = 0;
    int            seen_valid = 0;

    pp_read_buffer #(.DATA_W(DW), .BLK_WORDS(NW)) dut_i (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_start(wr_start), .wr_first(wr_first), .wr_data(wr_data),
        .wr_full(wr_full),
        .rd_start(rd_start), .rd_valid(rd_valid), .rd_data(rd_data), .rd_idx(rd_idx),
        .rd_last(rd_last), .half_empty(half_empty), .half_full(half_full)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // output monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            seen_valid++;
            if (exp_data.size() == 0) begin
                chk(1'b0, "R5", "word with nothing expected", longint'(rd_data), 0);
            end else begin
                logic [DW-1:0] ed;
                int ei;
                int ew;
                ed = exp_data.pop_front();
                ei = exp_idx.pop_front();
                ew = exp_wc.pop_front();
                if (nread % NW == 0) blk_first_cyc = cyc;
                chk(rd_data == ed, "R2", "rd_data", longint'(rd_data), longint'(ed));
                chk(int'(rd_idx) == ei, "R2", "rd_idx", longint'(rd_idx), longint'(ei));
                chk(cyc >= ew + 2, "R7", "read too early (cycle)", cyc, ew + 2);
                nread++;
                chk(rd_last == (nread % NW == 0), "R9", "rd_last", rd_last,
                    (nread % NW == 0));
                if (rd_last) begin
                    blk_last_cyc = cyc;
                    chk(half_empty[rhalf] == 1'b1, "R8", "half freed with last word",
                        half_empty, rhalf);
                    rhalf ^= 1;
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc == 60000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<60000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic write_block(input int first, input logic [DW-1:0] seed, input int gap,
                               input bit acc, input bit spur, output int c0);
        c0 = 0;
        for (int k = 0; k < NW; k++) begin
            @(posedge clk); #1;
            if (k == 0) c0 = cyc;
            wr_valid = 1'b1;
            wr_start = (k == 0);
            wr_first = 2'(first);
            wr_data  = seed + DW'(k);
            if (acc) begin
                exp_data.push_back(seed + DW'(k));
                exp_idx.push_back((first + k) % NW);
                exp_wc.push_back(cyc);
            end
            if (spur && k == 1) begin
                @(posedge clk); #1;
                wr_start = 1'b1;   // stray start inside open block (R11)
                wr_data  = ~seed;
            end
            if (k < NW - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(posedge clk); #1;
                    wr_valid = 1'b0;
                    wr_start = 1'b0;
                end
            end
        end
        @(posedge clk); #1;
        wr_valid = 1'b0;
        wr_start = 1'b0;
    endtask

    task automatic read_pulse();
        @(posedge clk); #1;
        rd_start = 1'b1;
        @(posedge clk); #1;
        rd_start = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int c0;
        int sv;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(half_empty == 2'b11, "R1", "half_empty after reset", half_empty, 2'b11);
        chk(half_full == 2'b00, "R1", "half_full after reset", half_full, 2'b00);
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
        chk(wr_full == 1'b0, "R1", "wr_full after reset", wr_full, 0);

        // first block lands in half 0
        write_block(2, 64'hA000, 0, 1, 0, c0);
        @(negedge clk);
        chk(half_full == 2'b01, "R1", "first block in half 0", half_full, 2'b01);
        chk(half_empty == 2'b10, "R10", "half 0 busy", half_empty, 2'b10);

        // second block into half 1 while the first waits (R3, R4)
        write_block(1, 64'hB000, 1, 1, 0, c0);
        @(negedge clk);
        chk(half_full == 2'b11, "R3", "both halves filled", half_full, 2'b11);
        chk(wr_full == 1'b1, "R5", "wr_full with both occupied", wr_full, 1);

        // third block refused
        write_block(0, 64'hC000, 0, 0, 0, c0);
        @(negedge clk);
        chk(half_full == 2'b11, "R5", "refused block left halves", half_full, 2'b11);
        chk(exp_data.size() == 8, "R5", "expected words pending", exp_data.size(), 8);

        // drain half 0
        read_pulse();
        idle(8);
        @(negedge clk);
        chk(half_empty == 2'b01, "R8", "half 0 freed", half_empty, 2'b01);
        chk(half_full == 2'b10, "R10", "half_full cleared on free", half_full, 2'b10);

        // overlap: write into half 0 while draining half 1 (R4)
        fork
            write_block(3, 64'hD000, 0, 1, 0, c0);
            begin idle(1); read_pulse(); end
        join
        idle(10);
        // drain D, plus a second pulse during the drain that must be ignored (R6)
        read_pulse();
        read_pulse();
        idle(10);
        @(negedge clk);
        chk(exp_data.size() == 0, "R3", "all accepted words drained", exp_data.size(), 0);
        chk(half_empty == 2'b11, "R8", "both free", half_empty, 2'b11);

        // rd_start with nothing occupied is ignored (R6)
        sv = seen_valid;
        read_pulse();
        idle(6);
        chk(seen_valid == sv, "R6", "no output on empty start", seen_valid - sv, 0);

        // stray start inside an open block (R11)
        write_block(1, 64'hE000, 0, 1, 1, c0);
        read_pulse();
        idle(10);
        @(negedge clk);
        chk(exp_data.size() == 0, "R11", "stray start ignored", exp_data.size(), 0);
        chk(half_empty == 2'b11, "R11", "halves free after block", half_empty, 2'b11);

        // exact latency, gapless fill, drain armed at c0+1 (R6)
        fork
            write_block(0, 64'h1000, 0, 1, 0, c0);
            begin idle(1); read_pulse(); end
        join
        idle(8);
        chk(blk_first_cyc == c0 + 3, "R6", "first word cycle", blk_first_cyc, c0 + 3);
        chk(blk_last_cyc == c0 + 6, "R6", "last word cycle", blk_last_cyc, c0 + 6);

        // gapped fill: drain stalls behind the fill (R7)
        fork
            write_block(2, 64'h2000, 1, 1, 0, c0);
            begin idle(1); read_pulse(); end
        join
        idle(8);
        chk(blk_last_cyc == c0 + 8, "R7", "stalled last word cycle", blk_last_cyc, c0 + 8);

        // sweep: start index x fill gap x drain delay
        for (int f = 0; f < NW; f++) begin
            for (int g = 0; g < 3; g++) begin
                for (int d = 1; d <= 4; d++) begin
                    fork
                        write_block(f, DW'((f << 12) | (g << 8) | (d << 4)) << 8, g, 1, 0, c0);
                        begin idle(d); read_pulse(); end
                    join
                    idle(12);
                    @(negedge clk);
                    chk(exp_data.size() == 0 && half_empty == 2'b11, "R2",
                        "sweep block drained", exp_data.size(), 0);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule